// File: doc/BRIEF.md
# Static Memory Read Strobe Generator

This block runs one read access at a time on an external static-memory bus. A pulse on `start` launches an access. For that access the block drives an active-low read strobe and an active-low chip-select strobe. The chip-select strobe typically enables a data-bus transceiver, so it needs its own placement inside the access. Each strobe has a setup count, which is the delay from the start of the access to assertion, and a pulse count, which is how long the strobe stays asserted. Both strobes share one cycle count that sets the total length of the access. Any time left over after setup plus pulse is the hold phase.

All timing fields arrive in a compact, non-linear code that only covers a few separate ranges of clock counts. The block expands each code into a plain clock count when it accepts `start`. It keeps those counts for the whole access. It raises `done` for one clock in the last clock of the access.

Top module: `sm_rd_strobe_gen`

## Requirements
- R1: A setup code `s[5:0]` decodes to `s[4:0] + 128*s[5]` clocks, so it covers 0..31 and 128..159.
- R2: A pulse code `p[6:0]` decodes to `p[5:0] + 256*p[6]` clocks, so it covers 0..63 and 256..319.
- R3: A cycle code `c[8:0]` decodes to `c[6:0] + 256*c[8:7]` clocks. The access lasts that many clocks, or exactly one clock when the code decodes to 0.
- R4: Number the clocks of an access 0, 1, 2 and so on, where clock 0 is the clock after the edge that accepted `start`. `rd_n` is low in exactly the clocks k with S_rd <= k < S_rd + P_rd.
- R5: `cs_n` follows the same rule as R4 with its own setup and pulse counts, inside the same access as `rd_n`.
- R6: `busy` is high in every clock of the access. `done` is high only in the last clock of the access, and `busy` is low in the clock after that.
- R7: When setup plus pulse is longer than the cycle, the strobe is released at the end of the access and the access is not extended.
- R8: A setup of 0 asserts the strobe in clock 0. A pulse of 0 keeps the strobe high for the whole access.
- R9: `start` is ignored while `busy` is high, including in the clock where `done` is high. The running access keeps its timing.
- R10: The field inputs are sampled only on the edge that accepts `start`. Changes to them during an access have no effect on that access.
- R11: While the block is in reset and while it is idle, `rd_n` and `cs_n` are high and `busy` and `done` are low.
- R12: If `start` is held high, a new access is accepted in the first idle clock after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an access; taken only when idle |
| rd_setup_code | input | 6 | Coded read-strobe setup |
| rd_pulse_code | input | 7 | Coded read-strobe pulse |
| cs_setup_code | input | 6 | Coded chip-select setup |
| cs_pulse_code | input | 7 | Coded chip-select pulse |
| cycle_code | input | 9 | Coded shared cycle length |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock pulse in the last access clock |
| rd_n | output | 1 | Read strobe, active low |
| cs_n | output | 1 | Chip-select strobe, active low |

## Verification
The bench drives codes with the high range bits set. A decoder that drops or misplaces the range weights would give strobes and access lengths that are far too short. Directed accesses cover these cases:
- setup plus pulse running past the cycle, where a design without clipping would stretch the access or leave a strobe low while idle;
- zero setup, zero pulse and a zero cycle code, where an off-by-one design either misses clock 0 or asserts a strobe that should stay high;
- new start requests and changed field codes in the middle of an access and in its `done` clock, where a design that re-samples the inputs or restarts would change the running timing or skip the idle clock.

// File: rtl/sm_rd_strobe_gen.sv
module sm_rd_strobe_gen #(
  parameter int SET_W = 6,
  parameter int PUL_W = 7,
  parameter int CYC_W = 9,
  parameter int CYC_LOW_W = 7,
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SET_W-1:0] rd_setup_code,
  input  logic [PUL_W-1:0] rd_pulse_code,
  input  logic [SET_W-1:0] cs_setup_code,
  input  logic [PUL_W-1:0] cs_pulse_code,
  input  logic [CYC_W-1:0] cycle_code,
  output logic             busy,
  output logic             done,
  output logic             rd_n,
  output logic             cs_n
);
  localparam int SET_LOW_W = SET_W - 1;
  localparam int PUL_LOW_W = PUL_W - 1;
  localparam int SET_HI_WT = 4 << SET_LOW_W;
  localparam int PUL_HI_WT = 4 << PUL_LOW_W;
  localparam int CYC_HI_WT = 2 << CYC_LOW_W;

  typedef logic [CNT_W-1:0] cnt_t;

  function automatic cnt_t dec_setup(input logic [SET_W-1:0] c);
    return cnt_t'(c[SET_LOW_W-1:0]) + (c[SET_W-1] ? cnt_t'(SET_HI_WT) : '0);
  endfunction

  function automatic cnt_t dec_pulse(input logic [PUL_W-1:0] c);
    return cnt_t'(c[PUL_LOW_W-1:0]) + (c[PUL_W-1] ? cnt_t'(PUL_HI_WT) : '0);
  endfunction

  function automatic cnt_t dec_cycle(input logic [CYC_W-1:0] c);
    return cnt_t'(c[CYC_LOW_W-1:0]) + cnt_t'(c[CYC_W-1:CYC_LOW_W]) * cnt_t'(CYC_HI_WT);
  endfunction

  cnt_t cnt, cyc_q, rd_s_q, rd_e_q, cs_s_q, cs_e_q;
  logic accept, last;

  assign accept = start && !busy;
  assign last   = busy && ((cnt + cnt_t'(1)) >= cyc_q);
  assign done   = last;
  assign rd_n   = !(busy && cnt >= rd_s_q && cnt < rd_e_q);
  assign cs_n   = !(busy && cnt >= cs_s_q && cnt < cs_e_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      cyc_q  <= '0;
      rd_s_q <= '0;
      rd_e_q <= '0;
      cs_s_q <= '0;
      cs_e_q <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      cnt    <= '0;
      cyc_q  <= dec_cycle(cycle_code);
      rd_s_q <= dec_setup(rd_setup_code);
      rd_e_q <= dec_setup(rd_setup_code) + dec_pulse(rd_pulse_code);
      cs_s_q <= dec_setup(cs_setup_code);
      cs_e_q <= dec_setup(cs_setup_code) + dec_pulse(cs_pulse_code);
    end else if (busy) begin
      if (last) busy <= 1'b0;
      else      cnt  <= cnt + cnt_t'(1);
    end
  end

  p_idle_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_n && cs_n && !done));
  p_done_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && cnt == $past(cnt) + cnt_t'(1)));
  p_fields_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(cyc_q) && $stable(rd_s_q) && $stable(rd_e_q)
                         && $stable(cs_s_q) && $stable(cs_e_q)));
  p_no_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < cyc_q || cnt == '0));
  p_zero_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_e_q == rd_s_q) |-> rd_n);
endmodule

// File: tb/sm_rd_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module sm_rd_strobe_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [5:0] rs_c = '0, cs_c = '0;
  logic [6:0] rp_c = '0, cp_c = '0;
  logic [8:0] cy_c = '0;
  logic busy, done, rd_n, cs_n;

  int n_chk = 0, n_fail = 0;
  string tag = "R11";

  always #10 clk = ~clk;

  sm_rd_strobe_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rd_setup_code(rs_c), .rd_pulse_code(rp_c),
    .cs_setup_code(cs_c), .cs_pulse_code(cp_c),
    .cycle_code(cy_c), .busy(busy), .done(done), .rd_n(rd_n), .cs_n(cs_n));

  // behavioural reference
  int m_busy = 0, m_k = 0, m_len = 1, m_rs = 0, m_rp = 0, m_cs = 0, m_cp = 0;

  function automatic int set_val(input int c);
    return (c % 32) + ((c / 32) % 2) * 128;
  endfunction
  function automatic int pul_val(input int c);
    return (c % 64) + ((c / 64) % 2) * 256;
  endfunction
  function automatic int cyc_val(input int c);
    return (c % 128) + (c / 128) * 256;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_busy = 0;
    else if (m_busy != 0) begin
      if (m_k + 1 >= m_len) m_busy = 0;
      else m_k = m_k + 1;
    end else if (start) begin
      m_busy = 1; m_k = 0;
      m_len = (cyc_val(cy_c) == 0) ? 1 : cyc_val(cy_c);
      m_rs = set_val(rs_c); m_rp = pul_val(rp_c);
      m_cs = set_val(cs_c); m_cp = pul_val(cp_c);
    end
  end

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s/%s %s: actual %b expected %b at %0t", req, tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6", busy, m_busy != 0, "busy");
      chk("R6", done, (m_busy != 0) && (m_k + 1 >= m_len), "done");
      chk("R4", rd_n, !((m_busy != 0) && m_k >= m_rs && m_k < m_rs + m_rp), "rd_n");
      chk("R5", cs_n, !((m_busy != 0) && m_k >= m_cs && m_k < m_cs + m_cp), "cs_n");
    end
  end

  task automatic access(input int rs, input int rp, input int cs, input int cp, input int cy);
    @(negedge clk);
    rs_c = 6'(rs); rp_c = 7'(rp); cs_c = 6'(cs); cp_c = 7'(cp); cy_c = 9'(cy);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy != 0) @(negedge clk);
  endtask

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11", rd_n, 1'b1, "rd_n in reset");
    chk("R11", cs_n, 1'b1, "cs_n in reset");
    chk("R11", busy, 1'b0, "busy in reset");
    chk("R11", done, 1'b0, "done in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    tag = "R4";  access(3, 5, 1, 9, 20);
    tag = "R5";  access(2, 4, 0, 12, 15);
    // R1 R2 R3: upper ranges of every code
    tag = "R1";  access(6'b100010, 7'd3, 6'd1, 7'd40, 9'd180);
    tag = "R2";  access(6'd2, 7'b1000011, 6'd0, 7'b1000000, 9'b10_0000101);
    tag = "R3";  access(6'h3F, 7'h7F, 6'h20, 7'h40, 9'h1FF);
    // R7: setup+pulse beyond the cycle
    tag = "R7";  access(4, 20, 2, 7'h50, 10);
    // R8: zero setup and zero pulse
    tag = "R8";  access(0, 3, 5, 0, 12);
    tag = "R8";  access(0, 0, 0, 1, 1);
    // R3: zero cycle code gives a one-clock access
    tag = "R3";  access(0, 2, 1, 2, 0);
    // R9 R10: extra start and new codes mid-access and on the done clock
    tag = "R9";
    @(negedge clk);
    rs_c = 6'd2; rp_c = 7'd6; cs_c = 6'd1; cp_c = 7'd8; cy_c = 9'd14; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    tag = "R10";
    rs_c = 6'd0; rp_c = 7'd1; cs_c = 6'd9; cp_c = 7'd1; cy_c = 9'd3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R9", busy, 1'b0, "busy after start on done clock");
    while (m_busy != 0) @(negedge clk);
    // R12: start held high across done
    tag = "R12";
    rs_c = 6'd1; rp_c = 7'd2; cs_c = 6'd0; cp_c = 7'd4; cy_c = 9'd6; start = 1'b1;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk("R12", busy, 1'b0, "idle clock after done");
    @(negedge clk);
    chk("R12", busy, 1'b1, "restart with start held");
    start = 1'b0;
    while (m_busy != 0) @(negedge clk);
    tag = "rand";
    for (int i = 0; i < 40; i++)
      access($urandom_range(0, 63), $urandom_range(0, 127), $urandom_range(0, 63),
             $urandom_range(0, 127), (i % 8 == 0) ? $urandom_range(0, 511) : $urandom_range(0, 60));
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule